// File: doc/BRIEF.md
# DDR DRAM Device-Side Command Decoder and Bank Tracker

This block sits on the device side of a four-bank double data rate DRAM model. On every rising clock edge it samples the clock enable, the active-low chip select and the three active-low strobe lines (row strobe, column strobe, write enable). It also samples a two-bit bank number and a 13-bit address. From these it decodes one command per cycle. It keeps, for each bank, whether a row is open and which one. It follows the low-power state selected by the clock enable and stores the mode settings: CAS latency, burst length and burst ordering.

Address bit 10 has more than one meaning. During an activate it is an ordinary row bit. During a read or write it asks for an automatic close of that bank. During a precharge it widens the close to every bank. Commands that break the bank state rules, and mode words with reserved codes, raise a one-cycle error pulse and change no state. Data capture, strobe timing and the storage array are not part of this block. The stored latency and burst values are only reported, not applied to any data.

All outputs are registered. They show the effect of the command sampled at edge N from edge N onward.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: While synchronous reset `rst` is high, and after it, no bank is open, `pwr_state` is 0 (normal), `cas_lat` is 3'b010, `burst_len` is 2, `burst_interleave` is 0, and the pulses `cmd_err`, `auto_pre` and `all_pre` are low.
- R2: Command codes are formed from {cs_n, ras_n, cas_n, we_n}:
  - activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000, no-op 0111.
  - With cs_n high the cycle is a no-op, whatever the other lines show.
- R3: An activate to an idle bank opens that bank and records `addr` as its row in `open_rows[b*13 +: 13]`. An activate to an open bank raises `cmd_err` and leaves the recorded row unchanged.
- R4: A read or write to an open bank copies `addr[COL_W-1:0]` into `rw_col`. A read or write to an idle bank raises `cmd_err` and leaves `rw_col` unchanged.
- R5: A read or write to an open bank with `addr[10]` high pulses `auto_pre` and closes that bank. With `addr[10]` low the bank stays open.
- R6: A precharge with `addr[10]` low closes only bank `ba`. A precharge with `addr[10]` high closes every bank and pulses `all_pre`.
- R7: An auto refresh while any bank is open raises `cmd_err`. With all banks idle it is accepted with no error.
- R8: A mode set with `ba`=0 stores its fields and leaves `addr[12:7]` unused:
  - `addr[2:0]`: burst length (001=2, 010=4, 011=8).
  - `addr[3]`: interleaved order.
  - `addr[6:4]`: CAS latency code, legal values 010 (2), 011 (3) and 110 (2.5), reported raw on `cas_lat`.
  - Any other length or latency code raises `cmd_err` and keeps the previous values.
  - A mode set with a nonzero `ba` changes nothing.
- R9: When `cke` is sampled low in the normal state, the block enters a low-power state and `pwr_state` becomes one of these:
  - 1 if all banks are idle (precharge power-down);
  - 2 if any bank is open (active power-down);
  - 3 if the cycle also carries an auto refresh with all banks idle (self refresh).
- R10: In a low-power state commands have no effect and banks keep their state. When `cke` is sampled high, `pwr_state` returns to 0, and that cycle's command is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank number |
| addr | input | 13 | Row, column or mode word |
| bank_open | output | 4 | One bit per bank, high while a row is open |
| open_rows | output | 52 | Recorded row per bank, bank b at bits b*13 +: 13 |
| rw_col | output | COL_W (10) | Column of the last accepted read or write; set COL_W to 9 for the x16 layout |
| auto_pre | output | 1 | One-cycle pulse on an accepted read/write with auto close |
| all_pre | output | 1 | One-cycle pulse on an all-bank precharge |
| cmd_err | output | 1 | One-cycle pulse on an illegal command or reserved mode code |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| cas_lat | output | 3 | Stored CAS latency code |
| burst_len | output | 4 | Stored burst length (2, 4 or 8) |
| burst_interleave | output | 1 | Stored burst order, 1 for interleaved |

## Verification
The assertions assume that inputs are stable around each rising edge and that the bank number always lies within the four banks. They also assume reset is held for at least one edge before commands start. The bench changes every input only on falling edges and returns the lines to a no-op after each command. It leaves `cke` low for whole cycles when exercising the low-power states, so each entry and exit falls on exactly one known edge.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

    localparam int NUM_BANKS = 4;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int AP_BIT    = 10;
    localparam int MODE_W    = 7;

    typedef enum logic [2:0] {
        CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF, CMD_MRS, CMD_BST
    } cmd_e;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_PPD  = 2'd1,
        PWR_APD  = 2'd2,
        PWR_SREF = 2'd3
    } pwr_e;

    typedef struct packed {
        logic [2:0] cl_code;
        logic [3:0] burst_len;
        logic       interleave;
    } mode_t;

    localparam mode_t MODE_RESET = '{cl_code: 3'b010, burst_len: 4'd2, interleave: 1'b0};

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_MRS;
                3'b110:  c = CMD_BST;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic logic [3:0] burst_from_code(input logic [2:0] code);
        case (code)
            3'b001:  return 4'd2;
            3'b010:  return 4'd4;
            3'b011:  return 4'd8;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic cl_legal(input logic [2:0] code);
        return (code == 3'b010) || (code == 3'b011) || (code == 3'b110);
    endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
    import ddr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       exec,
    input  cmd_e                       cmd,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [NUM_BANKS-1:0]       open_q,
    output logic [NUM_BANKS*ROW_W-1:0] rows_q,
    output logic [COL_W-1:0]           col_q,
    output logic                       err_q,
    output logic                       auto_pre_q,
    output logic                       all_pre_q
);
    logic is_rdwr, tgt_open, any_open, ap, rdwr_ok;

    always_comb begin
        is_rdwr  = (cmd == CMD_RD) || (cmd == CMD_WR);
        tgt_open = open_q[ba];
        any_open = |open_q;
        ap       = addr[AP_BIT];
        rdwr_ok  = exec && is_rdwr && tgt_open;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = (ba == BA_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[i]                  <= 1'b0;
                rows_q[i*ROW_W +: ROW_W]   <= '0;
            end else if (exec) begin
                case (cmd)
                    CMD_ACT: if (hit && !open_q[i]) begin
                        open_q[i]                <= 1'b1;
                        rows_q[i*ROW_W +: ROW_W] <= addr;
                    end
                    CMD_RD, CMD_WR: if (hit && open_q[i] && ap) open_q[i] <= 1'b0;
                    CMD_PRE: if (hit || ap) open_q[i] <= 1'b0;
                    default: ;
                endcase
            end
        end

        // R3
        bank_open_src_chk: assert property (@(posedge clk) disable iff (rst)
            (open_q[i] && !$past(open_q[i])) |->
                $past(exec && cmd == CMD_ACT && ba == BA_W'(i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q      <= '0;
            err_q      <= 1'b0;
            auto_pre_q <= 1'b0;
            all_pre_q  <= 1'b0;
        end else begin
            if (rdwr_ok) col_q <= addr[COL_W-1:0];
            err_q      <= exec && (((cmd == CMD_ACT) && tgt_open) ||
                                   (is_rdwr && !tgt_open) ||
                                   ((cmd == CMD_REF) && any_open));
            auto_pre_q <= rdwr_ok && ap;
            all_pre_q  <= exec && (cmd == CMD_PRE) && ap;
        end
    end

    // R6
    all_close_chk: assert property (@(posedge clk) disable iff (rst)
        all_pre_q |-> (open_q == '0));

    // R5
    auto_close_chk: assert property (@(posedge clk) disable iff (rst)
        auto_pre_q |-> !open_q[$past(ba)]);
endmodule

// File: rtl/ddr_mode_reg.sv
module ddr_mode_reg
    import ddr_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  cmd_e              cmd,
    input  logic [BA_W-1:0]   ba,
    input  logic [MODE_W-1:0] word,
    output mode_t             mode_q,
    output logic              err_q
);
    logic  sel, legal;
    mode_t nxt;

    always_comb begin
        sel            = exec && (cmd == CMD_MRS) && (ba == '0);
        nxt.burst_len  = burst_from_code(word[2:0]);
        nxt.interleave = word[3];
        nxt.cl_code    = word[6:4];
        legal          = (nxt.burst_len != 4'd0) && cl_legal(nxt.cl_code);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RESET;
            err_q  <= 1'b0;
        end else begin
            if (sel && legal) mode_q <= nxt;
            err_q <= sel && !legal;
        end
    end

    // R8
    burst_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q.burst_len == 4'd2) || (mode_q.burst_len == 4'd4) || (mode_q.burst_len == 4'd8));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $stable(mode_q));
endmodule

// File: rtl/ddr_pwr_ctrl.sv
module ddr_pwr_ctrl
    import ddr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  cmd_e cmd,
    input  logic any_open,
    output pwr_e state_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PWR_ON;
        end else if (state_q == PWR_ON) begin
            if (!cke) begin
                if (any_open)            state_q <= PWR_APD;
                else if (cmd == CMD_REF) state_q <= PWR_SREF;
                else                     state_q <= PWR_PPD;
            end
        end else if (cke) begin
            state_q <= PWR_ON;
        end
    end

    // R10
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != PWR_ON && cke) |=> (state_q == PWR_ON));

    // R9
    apd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PWR_ON && !cke && any_open) |=> (state_q == PWR_APD));

    // R10
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != PWR_ON && !cke) |=> $stable(state_q));
endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
    import ddr_cmd_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int COL_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [1:0]                 ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 bank_open,
    output logic [4*ROW_W-1:0]         open_rows,
    output logic [COL_W-1:0]           rw_col,
    output logic                       auto_pre,
    output logic                       all_pre,
    output logic                       cmd_err,
    output logic [1:0]                 pwr_state,
    output logic [2:0]                 cas_lat,
    output logic [3:0]                 burst_len,
    output logic                       burst_interleave
);
    cmd_e  cmd;
    pwr_e  pwr;
    mode_t mode;
    logic  exec, trk_err, mode_err;

    ddr_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    assign exec = cke && (pwr == PWR_ON);

    ddr_bank_tracker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_trk (
        .clk(clk), .rst(rst), .exec(exec), .cmd(cmd), .ba(ba), .addr(addr),
        .open_q(bank_open), .rows_q(open_rows), .col_q(rw_col),
        .err_q(trk_err), .auto_pre_q(auto_pre), .all_pre_q(all_pre)
    );

    ddr_mode_reg u_mode (
        .clk(clk), .rst(rst), .exec(exec), .cmd(cmd), .ba(ba),
        .word(addr[MODE_W-1:0]), .mode_q(mode), .err_q(mode_err)
    );

    ddr_pwr_ctrl u_pwr (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd),
        .any_open(|bank_open), .state_q(pwr)
    );

    assign cmd_err          = trk_err | mode_err;
    assign pwr_state        = pwr;
    assign cas_lat          = mode.cl_code;
    assign burst_len        = mode.burst_len;
    assign burst_interleave = mode.interleave;

    // R2
    deselect_nop_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cke && pwr == PWR_ON) |=> ($stable(bank_open) && !cmd_err && !all_pre));

    // R10
    lowpwr_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr != PWR_ON) |=> ($stable(bank_open) && !cmd_err));
endmodule

// File: tb/ddr_cmd_tracker_bench.sv
module ddr_cmd_tracker_bench;
    localparam int ROW_W = 13;
    localparam int COL_W = 10;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_MRS = 4'b0000, C_DESACT = 4'b1011;

    logic clk = 1'b0, rst = 1'b1, cke = 1'b1;
    logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic [ROW_W-1:0] addr = '0;
    logic [3:0] bank_open;
    logic [4*ROW_W-1:0] open_rows;
    logic [COL_W-1:0] rw_col;
    logic auto_pre, all_pre, cmd_err, burst_interleave;
    logic [1:0] pwr_state;
    logic [2:0] cas_lat;
    logic [3:0] burst_len;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    ddr_cmd_tracker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ddr_cmd_tracker (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .bank_open(bank_open), .open_rows(open_rows), .rw_col(rw_col),
        .auto_pre(auto_pre), .all_pre(all_pre), .cmd_err(cmd_err),
        .pwr_state(pwr_state), .cas_lat(cas_lat), .burst_len(burst_len),
        .burst_interleave(burst_interleave)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one command for one edge, then back to no-op; outputs valid on return
    task automatic issue(input logic k, input logic [3:0] c,
                         input logic [1:0] b, input logic [ROW_W-1:0] a);
        cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP; ba = '0; addr = '0;
    endtask

    function automatic logic [ROW_W-1:0] row_of(input int b);
        return open_rows[b*ROW_W +: ROW_W];
    endfunction

    task automatic t_reset();
        check("R1", "bank_open", bank_open, 0);
        check("R1", "pwr_state", pwr_state, 0);
        check("R1", "cas_lat", cas_lat, 3'b010);
        check("R1", "burst_len", burst_len, 2);
        check("R1", "interleave", burst_interleave, 0);
        check("R1", "pulses", {cmd_err, auto_pre, all_pre}, 0);
    endtask

    task automatic t_activate();
        issue(1, C_ACT, 2'd1, 13'h1ABC);
        check("R3", "open after act", bank_open, 4'b0010);
        check("R3", "row b1", row_of(1), 13'h1ABC);
        check("R3", "no err", cmd_err, 0);
        issue(1, C_ACT, 2'd1, 13'h0005);
        check("R3", "err on double act", cmd_err, 1);
        check("R3", "row held", row_of(1), 13'h1ABC);
        issue(1, C_NOP, 2'd0, 13'h0);
        check("R3", "err is a pulse", cmd_err, 0);
    endtask

    task automatic t_deselect();
        issue(1, C_DESACT, 2'd2, 13'h0777);
        check("R2", "deselect ignored", bank_open, 4'b0010);
        check("R2", "deselect no err", cmd_err, 0);
        issue(1, C_NOP, 2'd2, 13'h0777);
        check("R2", "nop no effect", bank_open, 4'b0010);
    endtask

    task automatic t_rdwr();
        issue(1, C_RD, 2'd1, 13'h03FF);
        check("R4", "rw_col", rw_col, 10'h3FF);
        check("R5", "no auto_pre", auto_pre, 0);
        check("R5", "bank stays open", bank_open, 4'b0010);
        issue(1, C_WR, 2'd0, 13'h0123);
        check("R4", "err on idle write", cmd_err, 1);
        check("R4", "col held", rw_col, 10'h3FF);
        issue(1, C_WR, 2'd1, 13'h1456);
        check("R5", "auto_pre pulse", auto_pre, 1);
        check("R5", "bank closed", bank_open, 4'b0000);
        check("R4", "col lower bits", rw_col, 10'h056);
        issue(1, C_RD, 2'd1, 13'h0001);
        check("R4", "err on idle read", cmd_err, 1);
    endtask

    task automatic t_precharge();
        issue(1, C_ACT, 2'd0, 13'h0011);
        issue(1, C_ACT, 2'd2, 13'h0022);
        issue(1, C_ACT, 2'd3, 13'h0400);
        check("R3", "three open, A10 as row bit", bank_open, 4'b1101);
        check("R3", "row b3 keeps bit 10", row_of(3), 13'h0400);
        issue(1, C_PRE, 2'd2, 13'h0000);
        check("R6", "single close", bank_open, 4'b1001);
        check("R6", "no all_pre", all_pre, 0);
        issue(1, C_PRE, 2'd0, 13'h0400);
        check("R6", "all closed", bank_open, 4'b0000);
        check("R6", "all_pre pulse", all_pre, 1);
    endtask

    task automatic t_refresh();
        issue(1, C_ACT, 2'd2, 13'h0099);
        issue(1, C_REF, 2'd0, 13'h0);
        check("R7", "refresh with open bank", cmd_err, 1);
        check("R7", "bank kept", bank_open, 4'b0100);
        issue(1, C_PRE, 2'd0, 13'h0400);
        issue(1, C_REF, 2'd0, 13'h0);
        check("R7", "refresh idle ok", cmd_err, 0);
    endtask

    task automatic t_mode();
        issue(1, C_MRS, 2'd0, 13'h003B);
        check("R8", "cl 3", cas_lat, 3'b011);
        check("R8", "bl 8", burst_len, 8);
        check("R8", "interleave", burst_interleave, 1);
        check("R8", "no err", cmd_err, 0);
        issue(1, C_MRS, 2'd0, 13'h0030);
        check("R8", "reserved bl err", cmd_err, 1);
        check("R8", "bl held", burst_len, 8);
        issue(1, C_MRS, 2'd0, 13'h0052);
        check("R8", "reserved cl err", cmd_err, 1);
        check("R8", "cl held", cas_lat, 3'b011);
        issue(1, C_MRS, 2'd1, 13'h0062);
        check("R8", "nonzero ba ignored", {cas_lat, burst_len}, {3'b011, 4'd8});
        issue(1, C_MRS, 2'd0, 13'h1F62);
        check("R8", "cl 2.5 code", cas_lat, 3'b110);
        check("R8", "bl 4", burst_len, 4);
        check("R8", "sequential", burst_interleave, 0);
    endtask

    task automatic t_power();
        issue(0, C_NOP, 2'd0, 13'h0);
        check("R9", "precharge power-down", pwr_state, 1);
        issue(0, C_ACT, 2'd0, 13'h0001);
        check("R10", "act ignored low", bank_open, 4'b0000);
        issue(1, C_ACT, 2'd0, 13'h0001);
        check("R10", "exit to normal", pwr_state, 0);
        check("R10", "exit cmd ignored", bank_open, 4'b0000);
        issue(1, C_ACT, 2'd3, 13'h0033);
        issue(0, C_NOP, 2'd0, 13'h0);
        check("R9", "active power-down", pwr_state, 2);
        issue(0, C_PRE, 2'd0, 13'h0400);
        check("R10", "bank kept in pd", bank_open, 4'b1000);
        issue(1, C_NOP, 2'd0, 13'h0);
        check("R10", "exit apd", pwr_state, 0);
        check("R10", "bank still open", bank_open, 4'b1000);
        issue(1, C_PRE, 2'd0, 13'h0400);
        issue(0, C_REF, 2'd0, 13'h0);
        check("R9", "self refresh", pwr_state, 3);
        check("R9", "no err on entry", cmd_err, 0);
        issue(0, C_NOP, 2'd0, 13'h0);
        check("R10", "self refresh held", pwr_state, 3);
        issue(1, C_NOP, 2'd0, 13'h0);
        check("R10", "exit self refresh", pwr_state, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_activate();
        t_deselect();
        t_rdwr();
        t_precharge();
        t_refresh();
        t_mode();
        t_power();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule